// File: doc/BRIEF.md
# Cascadable Dual 16/32-bit Timer

This block holds two 16-bit timers behind one small register interface. Each half has a control register, a count register and a period register. It also has its own enable, a prescaler, a choice of tick source and an optional gate input. The halves run independently, and each raises its own interrupt flag when its count wraps at the period.

Setting a single join bit in the lower control register fuses the halves into one 32-bit timer. In that mode the lower half's enable, prescaler, tick source and gate drive the pair, and the upper control register has no effect. The count and period are each split across the two halves, with the lower half holding the low word. A 32-bit period match raises the upper half's flag only. A converter trigger output pulses for one cycle on each period match of the upper half, or of the whole pair when joined, so that an external sampling unit can be paced.

Software writes the period, writes an initial count, then sets the enable bit. It can poll the flags and clear them by writing ones.

Top module: `cascade_timer`

## Requirements
- R1: After reset every control register and count register is 0, both period registers are 16'hFFFF, both flags are 0 and the trigger output is low.
- R2: A half whose enable (control bit 0) is 0 keeps its count unchanged.
- R3: Control bits [4:3] select the prescale ratio: code 0 gives 1:1, code 1 gives 1:8, code 2 gives 1:64 and code 3 gives 1:256. The first timer tick arrives on the ratio-th enabled cycle.
- R4: In 16-bit mode, a tick that arrives while a half's count equals its period reloads that count with 0 and sets that half's own flag (flag bit 0 lower, bit 1 upper). The other half is unaffected.
- R5: When lower control bit 5 is 1, the pair counts as one 32-bit value {upper count, lower count}. It wraps to 0 after matching {upper period, lower period}, and the upper control register is ignored.
- R6: In joined mode a 32-bit match sets flag bit 1 and never sets flag bit 0.
- R7: The trigger output is high for one cycle, in the cycle after an edge at which the upper half matches (16-bit mode) or the pair matches (joined mode). A lower-half match in 16-bit mode does not pulse it.
- R8: When control bit 2 is 1, a half advances its prescaler on each rising edge of its external count input rather than on every clock. In this mode the gate bit has no effect.
- R9: When control bit 1 is 1 and bit 2 is 0, the half counts only while its gate input is high. A period match in this mode does not set the flag, and the flag is instead set on the falling edge of the gate.
- R10: Address 3 reads the flags {upper, lower} in bits [1:0]. Writing to it clears each flag whose bit is 1 and leaves the others unchanged.
- R11: The prescaler counter clears whenever its half is disabled, so partial prescale progress does not carry over to the next enable.
- R12: A write to a count register takes effect at that clock edge and takes priority over a tick on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| addr | input | 3 | Register address: bit 2 selects the half; bits [1:0] are 0 control, 1 count, 2 period, 3 flags (lower half only) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for `addr`, combinational |
| extCnt | input | 2 | External count inputs, bit 0 lower, bit 1 upper |
| gateIn | input | 2 | Gate inputs, bit 0 lower, bit 1 upper |
| irq | output | 2 | Interrupt flags, bit 0 lower, bit 1 upper |
| convTrig | output | 1 | Converter trigger pulse |

## Verification
A wrong prescaler state shows up at the count register one full prescale period late or early. That can take up to 256 cycles to appear, so the stimulus runs each ratio past at least one tick. A broken carry or a broken 32-bit compare in joined mode is visible only when the low word wraps, so the joined case starts its count just below the word boundary and crosses it within a few cycles. Flag and trigger errors show up one cycle after the edge at which the match happens. A gate edge detector that misfires shows up as a flag set at the wrong time, or not set at all, relative to the gate's falling edge.

// File: rtl/ct_pkg.sv
package ct_pkg;
  localparam int CTRL_W     = 6;
  localparam int EN_B       = 0;
  localparam int GATE_B     = 1;
  localparam int EXT_B      = 2;
  localparam int PS_LO      = 3;
  localparam int JOIN_B     = 5;
  localparam int PS_LOG_MAX = 8;
  localparam int PS_W       = PS_LOG_MAX;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_CNT  = 2'd1;
  localparam logic [1:0] REG_PER  = 2'd2;
  localparam logic [1:0] REG_FLAG = 2'd3;

  typedef struct packed {
    logic tick;
    logic gateFall;
    logic gated;
    logic wrCnt;
  } halfStrb_t;

  typedef struct packed {
    halfStrb_t [1:0] half;
    logic            joined;
    logic [1:0]      clrFlag;
  } ctStrb_t;
endpackage

// File: rtl/ct_control.sv
module ct_control import ct_pkg::*; #(
  parameter int HALF_W = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         wrEn,
  input  logic [2:0]                   addr,
  input  logic [HALF_W-1:0]            wrData,
  input  logic [1:0]                   extCnt,
  input  logic [1:0]                   gateIn,
  output logic [1:0][CTRL_W-1:0]       ctrlQ,
  output logic [1:0][HALF_W-1:0]       perQ,
  output ctStrb_t                      strb
);
  logic [1:0][PS_W-1:0] psCnt;
  logic [1:0] extPrev, gatePrev;
  logic [1:0] effEn, gatedV, rawV, tickV, fallV, wrCntV;
  logic joined;

  function automatic logic [PS_W-1:0] termCount(input logic [1:0] sel);
    int sh;
    int v;
    sh = (sel == 2'd3) ? PS_LOG_MAX : 3 * int'(sel);
    v  = (1 << sh) - 1;
    return v[PS_W-1:0];
  endfunction

  assign joined = ctrlQ[0][JOIN_B];

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      effEn[h]  = ctrlQ[h][EN_B] & ~(joined & (h == 1));
      gatedV[h] = ctrlQ[h][GATE_B] & ~ctrlQ[h][EXT_B];
      rawV[h]   = effEn[h]
                & (ctrlQ[h][EXT_B] ? (extCnt[h] & ~extPrev[h]) : 1'b1)
                & (~gatedV[h] | gateIn[h]);
      tickV[h]  = rawV[h] & (psCnt[h] >= termCount(ctrlQ[h][PS_LO +: 2]));
      fallV[h]  = effEn[h] & gatedV[h] & gatePrev[h] & ~gateIn[h];
      wrCntV[h] = wrEn & (addr[2] == 1'(h)) & (addr[1:0] == REG_CNT);
    end
  end

  always_comb begin
    for (int h = 0; h < 2; h++) begin
      strb.half[h].tick     = tickV[h];
      strb.half[h].gateFall = fallV[h];
      strb.half[h].gated    = gatedV[h];
      strb.half[h].wrCnt    = wrCntV[h];
    end
    strb.joined  = joined;
    strb.clrFlag = (wrEn && addr == {1'b0, REG_FLAG}) ? wrData[1:0] : 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      perQ     <= '1;
      psCnt    <= '0;
      extPrev  <= '0;
      gatePrev <= '0;
    end else begin
      for (int h = 0; h < 2; h++) begin
        if (wrEn && addr[2] == 1'(h) && addr[1:0] == REG_CTRL)
          ctrlQ[h] <= wrData[CTRL_W-1:0];
        if (wrEn && addr[2] == 1'(h) && addr[1:0] == REG_PER)
          perQ[h] <= wrData;
        if (!effEn[h])
          psCnt[h] <= '0;
        else if (rawV[h])
          psCnt[h] <= tickV[h] ? '0 : psCnt[h] + 1'b1;
      end
      extPrev  <= extCnt;
      gatePrev <= gateIn;
    end
  end

  for (genvar g = 0; g < 2; g++) begin : g_chk
    AST_PS_CLEAR_OFF: assert property (@(posedge clk) disable iff (!rstN)
      $past(!effEn[g]) |-> psCnt[g] == '0); // R11
  end
endmodule

// File: rtl/ct_datapath.sv
module ct_datapath import ct_pkg::*; #(
  parameter int HALF_W = 16
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctStrb_t                strb,
  input  logic [HALF_W-1:0]      wrData,
  input  logic [1:0][HALF_W-1:0] perQ,
  output logic [1:0][HALF_W-1:0] cntQ,
  output logic [1:0]             flags,
  output logic                   trig
);
  localparam int FULL_W = 2 * HALF_W;

  logic [FULL_W-1:0] full, perFull, fullNext;
  logic matchJ, gatedEff;
  logic [1:0] matchH, setFlag;
  logic [1:0][HALF_W-1:0] cntNext;

  assign full     = {cntQ[1], cntQ[0]};
  assign perFull  = {perQ[1], perQ[0]};
  assign matchJ   = strb.joined & strb.half[0].tick & (full == perFull);
  assign fullNext = matchJ ? '0 : full + 1'b1;
  assign gatedEff = strb.joined ? strb.half[0].gated : strb.half[1].gated;

  always_comb begin
    for (int h = 0; h < 2; h++)
      matchH[h] = ~strb.joined & strb.half[h].tick & (cntQ[h] == perQ[h]);

    cntNext = cntQ;
    if (strb.joined) begin
      if (strb.half[0].tick) begin
        cntNext[0] = fullNext[HALF_W-1:0];
        cntNext[1] = fullNext[FULL_W-1:HALF_W];
      end
    end else begin
      for (int h = 0; h < 2; h++)
        if (strb.half[h].tick)
          cntNext[h] = matchH[h] ? '0 : cntQ[h] + 1'b1;
    end
    for (int h = 0; h < 2; h++)
      if (strb.half[h].wrCnt) cntNext[h] = wrData;

    setFlag[0] = ~strb.joined & ((matchH[0] & ~strb.half[0].gated) | strb.half[0].gateFall);
    setFlag[1] = strb.joined
               ? ((matchJ & ~strb.half[0].gated) | strb.half[0].gateFall)
               : ((matchH[1] & ~strb.half[1].gated) | strb.half[1].gateFall);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ  <= '0;
      flags <= '0;
      trig  <= 1'b0;
    end else begin
      cntQ  <= cntNext;
      flags <= (flags & ~strb.clrFlag) | setFlag;
      trig  <= strb.joined ? matchJ : matchH[1];
    end
  end

  AST_LO_FLAG_QUIET_JOINED: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.joined) |-> !$rose(flags[0])); // R6
  AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    $past(!strb.joined && strb.half[0].tick && !strb.half[0].wrCnt && cntQ[0] == perQ[0])
      |-> cntQ[0] == '0); // R4
  AST_JOINED_CARRY: assert property (@(posedge clk) disable iff (!rstN)
    $past(strb.joined && strb.half[0].tick && !strb.half[1].wrCnt
          && cntQ[0] == '1 && full != perFull)
      |-> cntQ[1] == $past(cntQ[1]) + 1'b1); // R5
  AST_TRIG_SETS_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    trig |-> (flags[1] || $past(gatedEff))); // R7
endmodule

// File: rtl/cascade_timer.sv
module cascade_timer import ct_pkg::*; #(
  parameter int HALF_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [2:0]        addr,
  input  logic [HALF_W-1:0] wrData,
  output logic [HALF_W-1:0] rdData,
  input  logic [1:0]        extCnt,
  input  logic [1:0]        gateIn,
  output logic [1:0]        irq,
  output logic              convTrig
);
  logic [1:0][CTRL_W-1:0] ctrlQ;
  logic [1:0][HALF_W-1:0] perQ, cntQ;
  logic [1:0]             flags;
  ctStrb_t                strb;

  ct_control #(.HALF_W(HALF_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .extCnt(extCnt), .gateIn(gateIn), .ctrlQ(ctrlQ), .perQ(perQ), .strb(strb)
  );

  ct_datapath #(.HALF_W(HALF_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(wrData), .perQ(perQ),
    .cntQ(cntQ), .flags(flags), .trig(convTrig)
  );

  assign irq = flags;

  always_comb begin
    case (addr[1:0])
      REG_CTRL: rdData = {{(HALF_W-CTRL_W){1'b0}}, ctrlQ[addr[2]]};
      REG_CNT:  rdData = cntQ[addr[2]];
      REG_PER:  rdData = perQ[addr[2]];
      default:  rdData = addr[2] ? '0 : {{(HALF_W-2){1'b0}}, flags};
    endcase
  end
endmodule

// File: tb/cascade_timer_tb.sv
`timescale 1ns/100ps
module cascade_timer_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] addr = '0;
  logic [15:0] wrData = '0;
  logic [15:0] rdData;
  logic [1:0] extCnt = '0;
  logic [1:0] gateIn = '0;
  logic [1:0] irq;
  logic convTrig;
  int total = 0;
  int bad = 0;
  int trigSeen = 0;

  always #2.5 clk = ~clk;

  cascade_timer u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .extCnt(extCnt), .gateIn(gateIn), .irq(irq), .convTrig(convTrig)
  );

  always @(negedge clk) if (convTrig) trigSeen++;

  // {half, ps, period, cycles, expCount, expFlags, expTrig}
  localparam logic [54:0] VEC [8] = '{
    {1'b0, 2'd0, 16'd10,  16'd5,   16'd5, 2'b00, 2'd0},
    {1'b0, 2'd0, 16'd4,   16'd5,   16'd0, 2'b01, 2'd0},
    {1'b0, 2'd0, 16'd4,   16'd7,   16'd2, 2'b01, 2'd0},
    {1'b0, 2'd1, 16'd100, 16'd20,  16'd2, 2'b00, 2'd0},
    {1'b0, 2'd2, 16'd1,   16'd130, 16'd0, 2'b01, 2'd0},
    {1'b0, 2'd3, 16'd9,   16'd600, 16'd2, 2'b00, 2'd0},
    {1'b0, 2'd1, 16'd0,   16'd16,  16'd0, 2'b01, 2'd0},
    {1'b1, 2'd0, 16'd3,   16'd9,   16'd1, 2'b10, 2'd2}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    addr = a;
    #0.2;
    d = rdData;
  endtask

  task automatic runEnabled(input logic h, input logic [15:0] base, input int n);
    wr({h, 2'b00}, base | 16'h1);
    idle(n - 1);
    wr({h, 2'b00}, base);
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int t0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    rd(3'd0, d); check("R1 ctrl lo", d, 0);
    rd(3'd4, d); check("R1 ctrl hi", d, 0);
    rd(3'd1, d); check("R1 count lo", d, 0);
    rd(3'd2, d); check("R1 period lo", d, 16'hFFFF);
    rd(3'd6, d); check("R1 period hi", d, 16'hFFFF);
    check("R1 flags", irq, 0);
    check("R1 trig", convTrig, 0);

    // vector table: R3 ratios, R4 independent wrap, R7 trigger source
    for (int i = 0; i < 8; i++) begin
      logic h;
      h = VEC[i][54];
      wr({h, 2'b01}, 16'd0);
      wr({h, 2'b10}, VEC[i][51:36]);
      wr(3'd3, 16'h3);
      t0 = trigSeen;
      runEnabled(h, {11'd0, VEC[i][53:52], 3'b000}, int'(VEC[i][35:20]));
      rd({h, 2'b01}, d);
      check($sformatf("R3/R4 vec%0d count", i), d, VEC[i][19:4]);
      rd(3'd3, d);
      check($sformatf("R4 vec%0d flags", i), d, VEC[i][3:2]);
      check($sformatf("R7 vec%0d trig", i), trigSeen - t0, VEC[i][1:0]);
    end
    wr(3'd3, 16'h3);

    // R2 hold while disabled
    wr(3'd1, 16'd7);
    idle(10);
    rd(3'd1, d); check("R2 hold", d, 7);

    // R5/R6/R7 joined mode, upper control set to junk
    wr(3'd0, 16'h0020);
    wr(3'd4, 16'h001F);
    gateIn[1] = 1'b1;
    wr(3'd2, 16'h0002);
    wr(3'd6, 16'h0001);
    wr(3'd5, 16'h0000);
    wr(3'd1, 16'hFFFE);
    t0 = trigSeen;
    runEnabled(1'b0, 16'h0020, 6);
    rd(3'd1, d); check("R5 joined low word", d, 1);
    rd(3'd5, d); check("R5 joined high word", d, 0);
    rd(3'd3, d); check("R6 joined flags", d, 2'b10);
    check("R7 joined trig", trigSeen - t0, 1);
    wr(3'd4, 16'h0000);
    wr(3'd0, 16'h0000);
    gateIn[1] = 1'b0;
    wr(3'd3, 16'h3);

    // R8 external edges, gate bit ignored
    wr(3'd2, 16'd100);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h0007);
    for (int k = 0; k < 3; k++) begin
      extCnt[0] = 1'b1; idle(2);
      extCnt[0] = 1'b0; idle(2);
    end
    wr(3'd0, 16'h0000);
    rd(3'd1, d); check("R8 ext edges", d, 3);

    // R9 gated counting, flag on gate fall only
    wr(3'd2, 16'd3);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h0003);
    gateIn[0] = 1'b1;
    idle(6);
    rd(3'd1, d); check("R9 gated count", d, 2);
    rd(3'd3, d); check("R9 no flag on match", d, 0);
    gateIn[0] = 1'b0;
    idle(4);
    rd(3'd1, d); check("R9 held while gate low", d, 2);
    check("R9 flag on gate fall", irq, 2'b01);
    wr(3'd0, 16'h0000);

    // R10 write-one-to-clear
    wr(3'd3, 16'h2);
    rd(3'd3, d); check("R10 other flag kept", d, 2'b01);
    wr(3'd3, 16'h1);
    rd(3'd3, d); check("R10 flag cleared", d, 0);

    // R11 prescaler cleared on disable
    wr(3'd2, 16'd100);
    wr(3'd1, 16'd0);
    runEnabled(1'b0, 16'h0008, 5);
    runEnabled(1'b0, 16'h0008, 5);
    rd(3'd1, d); check("R11 prescaler cleared", d, 0);

    // R12 count write wins over tick
    wr(3'd1, 16'd0);
    wr(3'd0, 16'h0001);
    idle(3);
    wr(3'd1, 16'd50);
    wr(3'd0, 16'h0000);
    rd(3'd1, d); check("R12 count write", d, 51);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule